// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block gathers 32 level-sensitive interrupt inputs and steers each one onto one of 15 output interrupt lines. Software reaches it through a small 32-bit register port with a word address. One register enables inputs one by one. A read-only register shows the sampled input levels. Four routing registers hold a 4-bit destination field for each input.

Each clock edge registers the input levels. An input counts as pending when its sampled level and its enable bit are both 1. Each output line is the OR of every pending input whose routing field selects that line. A field value of zero parks the input, so it drives no output. Reads are combinational from the word address, and writes take effect at the clock edge on which the write enable is high.

Top module: `intc_route_top`

## Requirements
- R1: After reset the enable word and all four routing words read as zero, and every output line is low.
- R2: Word address 0 holds the enable word. Bit n enables input n. A write stores the full 32-bit value and a read returns it.
- R3: Word address 1 reads the input levels as they were captured at the most recent clock edge, whatever the enable word holds. Writes to this address change nothing.
- R4: Word addresses 2 to 5 are routing words. Each reads back its last written value, and a write to one of them leaves the other three unchanged.
- R5: Routing fields are packed in reverse order. Input n uses word address 2 + (3 - n/8), bits [4*(n%8)+3 : 4*(n%8)]. Inputs 31 to 24 therefore share word address 2, and inputs 7 to 0 share word address 5.
- R6: A routing field of 0 connects its input to no output line.
- R7: A routing field k in the range 1 to 15 connects its input to output line k-1.
- R8: Output line j is high exactly when at least one input is both captured high and enabled, and has field j+1. The line falls in the cycle after the last such input drops or is disabled.
- R9: Word addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_i | input | 32 | Level interrupt inputs |
| irq_o | output | 15 | Routed interrupt output lines |

## Verification
The hardest case to reach is several enabled inputs that share one output line and then drop one at a time. The line has to stay high until the last of them falls. Random traffic seldom routes two inputs to the same line while both are high. A directed step therefore routes inputs from two different routing words to line 4 and lowers them one after the other. The field positions at both ends of the reversed packing are also set on purpose, at inputs 31, 24 and 0. Then a long random run mixes register writes, unmapped addresses and input changes, and a cycle-level model checks it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_IN       = 32;
  localparam int NUM_OUT      = 15;
  localparam int FIELD_W      = 4;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 3;
  localparam int FIELDS_PER_W = DATA_W / FIELD_W;
  localparam int ROUTE_WORDS  = NUM_IN / FIELDS_PER_W;
  localparam int ADDR_MASK    = 0;
  localparam int ADDR_STAT    = 1;
  localparam int ADDR_ROUTE0  = 2;
  typedef logic [FIELD_W-1:0] route_t;
endpackage

// File: rtl/intc_in_capture.sv
module intc_in_capture #(
  parameter int NUM_IN = intc_pkg::NUM_IN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_i,
  output logic [NUM_IN-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= irq_i;
  end
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NUM_IN  = intc_pkg::NUM_IN,
  parameter int DATA_W  = intc_pkg::DATA_W,
  parameter int ADDR_W  = intc_pkg::ADDR_W,
  parameter int FIELD_W = intc_pkg::FIELD_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_IN-1:0]               stat_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_IN-1:0]               mask_o,
  output logic [NUM_IN-1:0][FIELD_W-1:0]  field_o
);
  localparam int FPW   = DATA_W / FIELD_W;
  localparam int WORDS = NUM_IN / FPW;

  logic [NUM_IN-1:0]              mask_q;
  logic [WORDS-1:0][DATA_W-1:0]   route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wdata_i[NUM_IN-1:0];
      for (int w = 0; w < WORDS; w++) begin
        if (addr_i == ADDR_W'(ADDR_ROUTE0 + w)) route_q[w] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_MASK)) rdata_o[NUM_IN-1:0] = mask_q;
    if (addr_i == ADDR_W'(ADDR_STAT)) rdata_o[NUM_IN-1:0] = stat_i;
    for (int w = 0; w < WORDS; w++) begin
      if (addr_i == ADDR_W'(ADDR_ROUTE0 + w)) rdata_o = route_q[w];
    end
  end

  // highest inputs sit in the lowest routing word
  for (genvar n = 0; n < NUM_IN; n++) begin : g_field
    assign field_o[n] = route_q[WORDS-1-(n/FPW)][(n%FPW)*FIELD_W +: FIELD_W];
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/intc_out_mux.sv
module intc_out_mux #(
  parameter int NUM_IN  = intc_pkg::NUM_IN,
  parameter int NUM_OUT = intc_pkg::NUM_OUT,
  parameter int FIELD_W = intc_pkg::FIELD_W
) (
  input  logic [NUM_IN-1:0]              stat_i,
  input  logic [NUM_IN-1:0]              mask_i,
  input  logic [NUM_IN-1:0][FIELD_W-1:0] field_i,
  output logic [NUM_OUT-1:0]             irq_o
);
  logic [NUM_IN-1:0] pend;
  assign pend = stat_i & mask_i;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic [NUM_IN-1:0] hit;
    for (genvar n = 0; n < NUM_IN; n++) begin : g_in
      assign hit[n] = pend[n] && (field_i[n] == FIELD_W'(j + 1));
    end
    assign irq_o[j] = |hit;
  end
endmodule

// File: rtl/intc_route_top.sv
module intc_route_top
  import intc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_IN-1:0]   irq_i,
  output logic [NUM_OUT-1:0]  irq_o
);
  logic [NUM_IN-1:0]              stat_q;
  logic [NUM_IN-1:0]              mask_q;
  logic [NUM_IN-1:0][FIELD_W-1:0] field;

  intc_in_capture #(.NUM_IN(NUM_IN)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .stat_o (stat_q)
  );

  intc_regfile #(
    .NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .stat_i  (stat_q),
    .rdata_o (rdata_o),
    .mask_o  (mask_q),
    .field_o (field)
  );

  intc_out_mux #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .FIELD_W(FIELD_W)
  ) u_mux (
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .field_i (field),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/intc_route_chk.sv
module intc_route_chk
  import intc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_IN-1:0]  irq_i,
  input logic [NUM_OUT-1:0] irq_o,
  input logic [NUM_IN-1:0]  stat_q,
  input logic [NUM_IN-1:0]  mask_q
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_mask_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(wr_en_i) && $past(addr_i) == ADDR_W'(ADDR_MASK) && addr_i == ADDR_W'(ADDR_MASK)
    |-> rdata_o[NUM_IN-1:0] == $past(wdata_i[NUM_IN-1:0]));

  p_status_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && addr_i == ADDR_W'(ADDR_STAT) |-> rdata_o[NUM_IN-1:0] == $past(irq_i));

  p_route_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(wr_en_i) && $past(addr_i) == ADDR_W'(ADDR_ROUTE0) && addr_i == ADDR_W'(ADDR_ROUTE0)
    |-> $stable(rdata_o));

  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & mask_q) == '0 |-> irq_o == '0);

  p_lines_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones(stat_q & mask_q));

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i >= ADDR_W'(ADDR_ROUTE0 + ROUTE_WORDS) |-> rdata_o == '0);
endmodule

bind intc_route_top intc_route_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_i   (irq_i),
  .irq_o   (irq_o),
  .stat_q  (stat_q),
  .mask_q  (mask_q)
);

// File: tb/intc_route_top_tb.sv
module intc_route_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irq = '0;
  logic [14:0] irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] m_mask = '0;
  logic [31:0] m_stat = '0;
  logic [31:0] m_route [4] = '{default: '0};

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_route_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .irq_o(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] exp_lines();
    logic [14:0] e = '0;
    for (int n = 0; n < 32; n++) begin
      int f = int'((m_route[3 - n/8] >> (4*(n%8))) & 32'hF);
      if (m_stat[n] && m_mask[n] && f != 0) e[f-1] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    if (a == 3'd0) return m_mask;
    if (a == 3'd1) return m_stat;
    if (a >= 3'd2 && a <= 3'd5) return m_route[int'(a) - 2];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_mask = '0; m_stat = '0;
      for (int w = 0; w < 4; w++) m_route[w] = '0;
    end else begin
      if (wr_en) begin
        if (addr == 3'd0) m_mask = wdata;
        if (addr >= 3'd2 && addr <= 3'd5) m_route[int'(addr) - 2] = wdata;
      end
      m_stat = irq;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R8 irq_o vs model", {17'b0, irq_out}, {17'b0, exp_lines()});
      case (addr)
        3'd0:       chk("R2 mask readback", rdata, exp_read(addr));
        3'd1:       chk("R3 status readback", rdata, exp_read(addr));
        3'd6, 3'd7: chk("R9 unmapped readback", rdata, exp_read(addr));
        default:    chk("R4 routing readback", rdata, exp_read(addr));
      endcase
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 outputs low", {17'b0, irq_out}, '0);
    rd(3'd0, d); chk("R1 mask zero", d, '0);
    for (int a = 2; a <= 5; a++) begin
      rd(3'(a), d); chk("R1 routing zero", d, '0);
    end
    // R6 all enabled, all high, no routing
    wr(3'd0, 32'hFFFF_FFFF);
    irq = 32'hFFFF_FFFF; step();
    chk("R6 unrouted inputs quiet", {17'b0, irq_out}, '0);
    // R5/R7 reversed packing, top word
    wr(3'd2, 32'hF000_0005);
    irq = 32'h0100_0000; step();
    chk("R5 input24 to line4", {17'b0, irq_out}, 32'h0000_0010);
    irq = 32'h8000_0000; step();
    chk("R7 input31 field15 to line14", {17'b0, irq_out}, 32'h0000_4000);
    wr(3'd5, 32'h0000_0001);
    irq = 32'h0000_0001; step();
    chk("R7 input0 field1 to line0", {17'b0, irq_out}, 32'h0000_0001);
    // R8 shared line stays up until last source drops
    wr(3'd4, 32'h0000_0005);
    irq = 32'h0100_0100; step();
    chk("R8 two sources line4", {17'b0, irq_out}, 32'h0000_0010);
    irq = 32'h0000_0100; step();
    chk("R8 one source left line4", {17'b0, irq_out}, 32'h0000_0010);
    irq = 32'h0; step();
    chk("R8 line4 falls", {17'b0, irq_out}, '0);
    // R8 mask gating, R3 status ignores mask
    irq = 32'h0100_0000;
    wr(3'd0, ~32'h0100_0000);
    chk("R8 disabled input quiet", {17'b0, irq_out}, '0);
    rd(3'd1, d); chk("R3 status ignores mask", d, 32'h0100_0000);
    // R3 write ignored and capture timing
    wr(3'd1, 32'hDEAD_BEEF);
    rd(3'd1, d); chk("R3 status write ignored", d, 32'h0100_0000);
    irq = 32'h0000_00A5; #1;
    rd(3'd1, d); chk("R3 status before edge", d, 32'h0100_0000);
    step();
    rd(3'd1, d); chk("R3 status after edge", d, 32'h0000_00A5);
    // R9 unmapped
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1234_5678);
    rd(3'd6, d); chk("R9 addr6 zero", d, '0);
    rd(3'd7, d); chk("R9 addr7 zero", d, '0);
    rd(3'd0, d); chk("R9 mask untouched", d, ~32'h0100_0000);
    // R4 isolation
    wr(3'd3, 32'h1234_5678);
    rd(3'd2, d); chk("R4 word2 kept", d, 32'hF000_0005);
    rd(3'd3, d); chk("R4 word3 stored", d, 32'h1234_5678);
    rd(3'd4, d); chk("R4 word4 kept", d, 32'h0000_0005);
    rd(3'd5, d); chk("R4 word5 kept", d, 32'h0000_0001);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      addr  = 3'($urandom_range(0, 7));
      wdata = $urandom();
      wr_en = ($urandom_range(0, 9) < 3);
      if ($urandom_range(0, 3) == 0) irq = $urandom() & $urandom();
      step();
    end
    wr_en = 1'b0;
    step();
    finish_run();
  end
endmodule